// File: doc/BRIEF.md
# Bidirectional Parity-Checking Bus Transceiver

This block moves a data word between two ports, called A and B, without changing it. A direction input picks which port is the source. An active-low enable decides whether any port drives at all. The block has no pads, so each port is split into an input vector, an output vector and a single drive-enable bit. The pad ring or an on-chip bus fabric combines these into a real bidirectional net. The block is purely combinational and holds no state.

A single parity line goes with the data, and its role depends on the direction. When sending from A to B, the block computes a parity bit over the A word and drives it onto the line. When receiving from B to A, the block takes the line as an input, checks it against the B word, and pulls an active-low error flag low if the check fails. A sense-select input chooses between odd and even parity. The control inputs are decoded into three named transfer modes:

- `MODE_FLOAT`: the enable is inactive.
- `MODE_SEND`: the enable is active and the direction is A to B.
- `MODE_RECV`: the enable is active and the direction is B to A.

The mode changes immediately whenever the control inputs change.

Top module: `parity_bus_xcvr`

## Requirements
- R1: In `MODE_SEND` (`oe_n`=0, `dir_send`=1), `b_oe` is 1, `b_out` equals `a_in` bit for bit, and `a_oe` is 0.
- R2: In `MODE_RECV` (`oe_n`=0, `dir_send`=0), `a_oe` is 1, `a_out` equals `b_in` bit for bit, and `b_oe` is 0.
- R3: In `MODE_FLOAT` (`oe_n`=1), `a_oe`, `b_oe` and `par_oe` are all 0, whatever `dir_send` is.
- R4: When a port's drive enable is 0, its output vector or output bit is all zeros.
- R5: In `MODE_SEND`, `par_out` is set so that the number of ones in `a_in` plus `par_out` is odd when `odd_sel`=1 and even when `odd_sel`=0. For example, with even parity selected and five ones on A, `par_out` is 1.
- R6: In `MODE_RECV`, `err_n` is 0 exactly when the number of ones in `b_in` plus `par_in` does not have the selected sense (odd when `odd_sel`=1, even when `odd_sel`=0). For example, with odd parity selected, `par_in`=1 and three ones on B, `err_n` is 0.
- R7: `par_oe` is 1 only in `MODE_SEND`.
- R8: `err_n` is 1 in `MODE_SEND` and in `MODE_FLOAT`.
- R9: In `MODE_SEND`, `par_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_send | input | 1 | 1: A drives B; 0: B drives A |
| oe_n | input | 1 | Active-low enable; 1 releases every port |
| odd_sel | input | 1 | 1: odd parity; 0: even parity |
| a_in | input | WIDTH | Value seen on the A port |
| a_out | output | WIDTH | Value to drive onto the A port |
| a_oe | output | 1 | A port drive enable |
| b_in | input | WIDTH | Value seen on the B port |
| b_out | output | WIDTH | Value to drive onto the B port |
| b_oe | output | 1 | B port drive enable |
| par_in | input | 1 | Value seen on the parity line |
| par_out | output | 1 | Generated parity bit to drive |
| par_oe | output | 1 | Parity line drive enable |
| err_n | output | 1 | Active-low parity error on received data |

## Verification
The hardest case to reach from the ports is a received word whose parity line contradicts the word. In normal traffic the parity line is produced by a matching generator, so a mismatch never appears on its own. The stimulus therefore drives `par_in` directly, and for every one of the 256 words it tries both values under both senses. This means every word is checked once with correct parity and once with corrupted parity. The same sweep repeats in `MODE_SEND`, where `par_in` must be ignored. It also repeats in `MODE_FLOAT`, so that every word sees every combination of direction, enable, sense and parity input.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    typedef enum logic [1:0] {
        MODE_FLOAT = 2'd0,
        MODE_SEND  = 2'd1,
        MODE_RECV  = 2'd2
    } xfer_mode_e;

endpackage

// File: rtl/pbx_mode_decode.sv
module pbx_mode_decode
    import pbx_pkg::*;
(
    input  logic       dir_send,
    input  logic       oe_n,
    output xfer_mode_e mode
);

    always_comb begin
        if (oe_n)
            mode = MODE_FLOAT;
        else if (dir_send)
            mode = MODE_SEND;
        else
            mode = MODE_RECV;
    end

endmodule

// File: rtl/pbx_parity_tree.sv
module pbx_parity_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data,
    output logic             odd_ones
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    genvar li;
    generate
        for (li = 0; li < LEAVES; li++) begin : g_leaf
            if (li < WIDTH) begin : g_real
                assign node[LEAVES-1+li] = data[li];
            end else begin : g_pad
                assign node[LEAVES-1+li] = 1'b0;
            end
        end
    endgenerate

    genvar ni;
    generate
        for (ni = 0; ni < LEAVES - 1; ni++) begin : g_inner
            assign node[ni] = node[2*ni+1] ^ node[2*ni+2];
        end
    endgenerate

    assign odd_ones = node[0];

endmodule

// File: rtl/pbx_parity_unit.sv
module pbx_parity_unit
    import pbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  xfer_mode_e       mode,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             par_in,
    input  logic             odd_sel,
    output logic             par_out,
    output logic             par_oe,
    output logic             err_n
);

    logic [WIDTH-1:0] tree_in;
    logic             word_odd;

    always_comb begin
        tree_in = (mode == MODE_SEND) ? a_in : b_in;
    end

    pbx_parity_tree #(.WIDTH(WIDTH)) tree_i (
        .data     (tree_in),
        .odd_ones (word_odd)
    );

    always_comb begin
        par_out = 1'b0;
        par_oe  = 1'b0;
        err_n   = 1'b1;
        unique case (mode)
            MODE_SEND: begin
                par_oe  = 1'b1;
                par_out = word_odd ^ odd_sel;
            end
            MODE_RECV: begin
                err_n = ((word_odd ^ par_in) == odd_sel);
            end
            default: begin
                par_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/parity_bus_xcvr.sv
module parity_bus_xcvr
    import pbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             dir_send,
    input  logic             oe_n,
    input  logic             odd_sel,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             err_n
);

    xfer_mode_e mode;

    pbx_mode_decode mode_i (
        .dir_send (dir_send),
        .oe_n     (oe_n),
        .mode     (mode)
    );

    always_comb begin
        a_out = '0;
        b_out = '0;
        a_oe  = 1'b0;
        b_oe  = 1'b0;
        unique case (mode)
            MODE_SEND: begin
                b_oe  = 1'b1;
                b_out = a_in;
            end
            MODE_RECV: begin
                a_oe  = 1'b1;
                a_out = b_in;
            end
            default: begin
                a_oe = 1'b0;
            end
        endcase
    end

    pbx_parity_unit #(.WIDTH(WIDTH)) par_i (
        .mode    (mode),
        .a_in    (a_in),
        .b_in    (b_in),
        .par_in  (par_in),
        .odd_sel (odd_sel),
        .par_out (par_out),
        .par_oe  (par_oe),
        .err_n   (err_n)
    );

endmodule

// File: rtl/parity_bus_xcvr_chk.sv
module parity_bus_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             dir_send,
    input logic             oe_n,
    input logic             odd_sel,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             par_in,
    input logic             par_out,
    input logic             par_oe,
    input logic             err_n
);

    always_comb begin
        if (!oe_n && dir_send) begin
            a_r1_send_path: assert (b_oe && !a_oe && (b_out == a_in))
                else $error("R1 send path wrong");
            a_r5_send_parity: assert ((($countones(a_in) + int'(par_out)) % 2) == int'(odd_sel))
                else $error("R5 generated parity wrong");
        end
        if (!oe_n && !dir_send) begin
            a_r2_recv_path: assert (a_oe && !b_oe && (a_out == b_in))
                else $error("R2 receive path wrong");
            a_r6_recv_check: assert (err_n == ((($countones(b_in) + int'(par_in)) % 2) == int'(odd_sel)))
                else $error("R6 error flag wrong");
        end
        if (oe_n) begin
            a_r3_float: assert (!a_oe && !b_oe && !par_oe)
                else $error("R3 port driving while disabled");
        end
        a_r4_released_zero: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0) && (par_oe || !par_out))
            else $error("R4 released output not zero");
        a_r7_par_drive: assert (!par_oe || (!oe_n && dir_send))
            else $error("R7 parity line driven outside send");
        a_r8_err_quiet: assert (err_n || (!oe_n && !dir_send))
            else $error("R8 error flag outside receive");
    end

endmodule

bind parity_bus_xcvr parity_bus_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
    .dir_send (dir_send),
    .oe_n     (oe_n),
    .odd_sel  (odd_sel),
    .a_in     (a_in),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_in     (b_in),
    .b_out    (b_out),
    .b_oe     (b_oe),
    .par_in   (par_in),
    .par_out  (par_out),
    .par_oe   (par_oe),
    .err_n    (err_n)
);

// File: tb/parity_bus_xcvr_tb_top.sv
module parity_bus_xcvr_tb_top;

    localparam int W = 8;

    bit         clk = 1'b0;
    bit         rst = 1'b1;
    logic       dir_send, oe_n, odd_sel, par_in;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, b_out;
    logic       a_oe, b_oe, par_out, par_oe, err_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    parity_bus_xcvr #(.WIDTH(W)) dut_i (
        .dir_send (dir_send),
        .oe_n     (oe_n),
        .odd_sel  (odd_sel),
        .a_in     (a_in),
        .a_out    (a_out),
        .a_oe     (a_oe),
        .b_in     (b_in),
        .b_out    (b_out),
        .b_oe     (b_oe),
        .par_in   (par_in),
        .par_out  (par_out),
        .par_oe   (par_oe),
        .err_n    (err_n)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (dir=%0b oe_n=%0b odd=%0b par_in=%0b a=%h b=%h)",
                     req, act, exp, dir_send, oe_n, odd_sel, par_in, a_in, b_in);
        end
    endtask

    task automatic apply(input logic d, input logic e, input logic o, input logic p,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        dir_send = d; oe_n = e; odd_sel = o; par_in = p; a_in = a; b_in = b;
        @(negedge clk);
    endtask

    task automatic check_all();
        logic send, recv;
        logic exp_par, exp_err_n;
        send = !oe_n && dir_send;
        recv = !oe_n && !dir_send;
        exp_par   = send ? (logic'($countones(a_in) % 2) ^ odd_sel) : 1'b0;
        exp_err_n = recv ? ((($countones(b_in) + int'(par_in)) % 2) == int'(odd_sel)) : 1'b1;
        if (send) begin
            chk("R1 b_oe", W'(b_oe), W'(1));
            chk("R1 a_oe", W'(a_oe), W'(0));
            chk("R1 b_out", b_out, a_in);
            chk("R5 par_out", W'(par_out), W'(exp_par));
            chk("R8 err_n in send", W'(err_n), W'(1));
        end else if (recv) begin
            chk("R2 a_oe", W'(a_oe), W'(1));
            chk("R2 b_oe", W'(b_oe), W'(0));
            chk("R2 a_out", a_out, b_in);
            chk("R6 err_n", W'(err_n), W'(exp_err_n));
        end else begin
            chk("R3 a_oe", W'(a_oe), W'(0));
            chk("R3 b_oe", W'(b_oe), W'(0));
            chk("R8 err_n in float", W'(err_n), W'(1));
        end
        chk("R7 par_oe", W'(par_oe), W'(send));
        if (!a_oe) chk("R4 a_out released", a_out, '0);
        if (!b_oe) chk("R4 b_out released", b_out, '0);
        if (!par_oe) chk("R4 par_out released", W'(par_out), W'(0));
    endtask

    initial begin : watchdog
        int cycles;
        cycles = 0;
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] ref_b;
        logic         ref_par;
        dir_send = 1'b0; oe_n = 1'b1; odd_sel = 1'b0; par_in = 1'b0;
        a_in = '0; b_in = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 initial a_oe", W'(a_oe), W'(0));
        chk("R3 initial b_oe", W'(b_oe), W'(0));
        chk("R3 initial par_oe", W'(par_oe), W'(0));
        chk("R8 initial err_n", W'(err_n), W'(1));

        // R5 example: even sense, five ones on A -> parity 1
        apply(1'b1, 1'b0, 1'b0, 1'b0, 8'b0001_1111, 8'h00);
        chk("R5 example par_out", W'(par_out), W'(1));
        // R6 example: odd sense, parity 1, three ones on B -> error
        apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'b0000_0111);
        chk("R6 example err_n", W'(err_n), W'(0));

        // R9: par_in toggled in send mode leaves every output unchanged
        for (int w = 0; w < 256; w += 37) begin
            apply(1'b1, 1'b0, w[0], 1'b0, W'(w), W'(w) ^ 8'h3C);
            ref_b = b_out; ref_par = par_out;
            apply(1'b1, 1'b0, w[0], 1'b1, W'(w), W'(w) ^ 8'h3C);
            chk("R9 b_out with par_in", b_out, ref_b);
            chk("R9 par_out with par_in", W'(par_out), W'(ref_par));
            chk("R9 err_n with par_in", W'(err_n), W'(1));
        end

        // Exhaustive sweep
        for (int d = 0; d < 2; d++)
            for (int e = 0; e < 2; e++)
                for (int o = 0; o < 2; o++)
                    for (int p = 0; p < 2; p++)
                        for (int w = 0; w < 256; w++) begin
                            apply(d[0], e[0], o[0], p[0], W'(w), W'(w) ^ 8'hA5);
                            check_all();
                        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule